// File: doc/BRIEF.md
# Interrupt Source Pending Controller

This block holds the pending bits for a small group of wired interrupt sources belonging to one interrupt domain. Every source carries a three-bit mode code that makes it inactive, edge-triggered on a rising or falling input, or level-sensitive with an active-high or active-low input. The live inputs pass through a two-flop synchronizer. Detected events, together with software writes, then drive one small pending state machine per source. The pending bits leave the block as a parallel vector, where bit k belongs to source number k+1.

Software reaches the pending bits through a write port made of a valid strobe, a set/clear select and a source number. Whether such a write takes effect depends on the source's mode, on its synchronized input level and on the domain's delivery style, which is selected by `msg_mode` (1 means interrupts are delivered as messages, 0 means direct delivery). The distinctive rule concerns level-sensitive sources in message mode. A software set is accepted only while the source is still asserting its input, so an interrupt service routine can re-arm the source without creating a spurious interrupt.

Each source's machine has two states, `ST_IDLE` and `ST_PEND`. Every clock cycle it picks exactly one named transition:

- `TR_HOLD` keeps the current state.
- `TR_HW_SET` moves from `ST_IDLE` to `ST_PEND` on a hardware event.
- `TR_SW_SET` moves from `ST_IDLE` to `ST_PEND` on an accepted software set.
- `TR_SW_CLR` moves from `ST_PEND` to `ST_IDLE` on an accepted software clear.
- `TR_LVL_DROP` moves from `ST_PEND` to `ST_IDLE` when a direct-mode level source stops asserting.
- `TR_FORCE_OFF` moves from `ST_PEND` to `ST_IDLE` when the source's mode is inactive.

Top module: `irq_pend_ctrl`

## Requirements
- R1: Mode codes are 0 inactive, 1 rising edge, 2 falling edge, 3 level-high and 4 level-low; codes 5 to 7 behave as inactive. An inactive source's pending bit is held at 0, and software writes to it have no effect.
- R2: A write is presented with `wr_valid`=1, `wr_set`=1 to set or 0 to clear, and `wr_num` giving the source number; it acts on the next rising clock edge. Numbers 0 and numbers above NUM_SRC are ignored. Pending bit k belongs to source k+1.
- R3: For edge-mode sources, software set and clear act on the pending bit unconditionally.
- R4: In an edge mode, an input transition of the configured polarity sets the pending bit on the third rising clock edge after the input changes (two synchronizer edges plus one). A transition of the opposite polarity does not set it.
- R5: With `msg_mode`=0, a level source's pending bit equals its asserted state (input high for level-high, input low for level-low), with the same three-edge latency. Software set and clear are ignored.
- R6: With `msg_mode`=1, a software clear of a level source is ignored.
- R7: With `msg_mode`=1, a software set of a level-high source is accepted only while its synchronized input is high. For a level-low source it is accepted only while the input is low.
- R8: With `msg_mode`=1, a level source's pending bit is set when the synchronized input changes into the asserted state. Deassertion does not clear it.
- R9: When a hardware set event and a software clear hit the same source in the same cycle, the set wins.
- R10: After reset, all pending bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_mode | input | 1 | Domain delivery style: 1 message, 0 direct |
| src_in | input | NUM_SRC | Raw interrupt inputs; bit k is source k+1 |
| src_mode | input | NUM_SRC*3 | Per-source mode codes; source k+1 at bits [3k+2:3k] |
| wr_valid | input | 1 | Write strobe |
| wr_set | input | 1 | 1 sets, 0 clears |
| wr_num | input | clog2(NUM_SRC+1) | Source number of the write |
| pend | output | NUM_SRC | Pending bits; bit k is source k+1 |

## Verification
Each pending bit is exactly the state of one source's machine, so a wrong state appears on `pend` at the first falling edge after the clock edge that caused it. The exceptions are faults in the synchronizer or in the previous-level register: these shift a hardware-set bit away from its third edge, and the bench catches that by checking one cycle early and then on time. Filtered writes are checked by comparing the whole vector after each write. This exposes a write that lands on the wrong source, or one that should have been dropped, in the very next cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MD_OFF  = 3'd0;
    localparam logic [MODE_W-1:0] MD_RISE = 3'd1;
    localparam logic [MODE_W-1:0] MD_FALL = 3'd2;
    localparam logic [MODE_W-1:0] MD_HIGH = 3'd3;
    localparam logic [MODE_W-1:0] MD_LOW  = 3'd4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pend_state_e;

    typedef enum logic [2:0] {
        TR_HOLD      = 3'd0,
        TR_HW_SET    = 3'd1,
        TR_SW_SET    = 3'd2,
        TR_SW_CLR    = 3'd3,
        TR_LVL_DROP  = 3'd4,
        TR_FORCE_OFF = 3'd5
    } pend_trans_e;

    function automatic logic mode_is_edge(input logic [MODE_W-1:0] m);
        return (m == MD_RISE) || (m == MD_FALL);
    endfunction

    function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
        return (m == MD_HIGH) || (m == MD_LOW);
    endfunction

    // Asserted state of a synchronized level under a given mode.
    function automatic logic level_asserted(input logic [MODE_W-1:0] m,
                                            input logic lvl);
        logic r;
        unique case (m)
            MD_RISE, MD_HIGH: r = lvl;
            MD_FALL, MD_LOW:  r = ~lvl;
            default:          r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_pend_sync.sv
module irq_pend_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/irq_pend_wr_dec.sv
module irq_pend_wr_dec #(
    parameter int NUM_SRC = 8,
    parameter int NUM_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic               wr_set,
    input  logic [NUM_W-1:0]   wr_num,
    output logic [NUM_SRC-1:0] sw_set,
    output logic [NUM_SRC-1:0] sw_clr
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_dec
        logic hit;
        assign hit       = wr_valid && (wr_num == NUM_W'(k + 1));
        assign sw_set[k] = hit & wr_set;
        assign sw_clr[k] = hit & ~wr_set;
    end

    // R2: at most one source is touched per write
    p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_set, sw_clr}));

    // R2: reserved and out-of-range numbers reach no source
    p_reserved_num_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_num == '0 || wr_num > NUM_W'(NUM_SRC)) |-> (sw_set == '0 && sw_clr == '0));

endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
    import irq_pend_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              msg_mode,
    input  logic              lvl,
    input  logic              sw_set,
    input  logic              sw_clr,
    output logic              pend
);

    pend_state_e state_q, state_d;
    pend_trans_e trans;
    logic        lvl_prev_q;
    logic        edge_md, level_md, off_md;
    logic        assert_now, assert_prev, assert_rise;

    assign edge_md     = mode_is_edge(mode);
    assign level_md    = mode_is_level(mode);
    assign off_md      = !(edge_md || level_md);
    assign assert_now  = level_asserted(mode, lvl);
    assign assert_prev = level_asserted(mode, lvl_prev_q);
    assign assert_rise = assert_now & ~assert_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev_q <= 1'b0;
        end else begin
            lvl_prev_q <= lvl;
        end
    end

    // Transition selection
    always_comb begin
        trans = TR_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                if (off_md) begin
                    trans = TR_HOLD;
                end else if (level_md && !msg_mode) begin
                    trans = assert_now ? TR_HW_SET : TR_HOLD;
                end else if (assert_rise) begin
                    trans = TR_HW_SET;
                end else if (sw_set && (edge_md || assert_now)) begin
                    trans = TR_SW_SET;
                end
            end
            ST_PEND: begin
                if (off_md) begin
                    trans = TR_FORCE_OFF;
                end else if (level_md && !msg_mode) begin
                    trans = assert_now ? TR_HOLD : TR_LVL_DROP;
                end else if (edge_md && sw_clr && !assert_rise) begin
                    trans = TR_SW_CLR;
                end
            end
        endcase
    end

    always_comb begin
        unique case (trans)
            TR_HW_SET, TR_SW_SET:                 state_d = ST_PEND;
            TR_SW_CLR, TR_LVL_DROP, TR_FORCE_OFF: state_d = ST_IDLE;
            default:                              state_d = state_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output
    always_comb begin
        pend = (state_q == ST_PEND);
    end

    // R1: an inactive mode leaves the bit clear next cycle
    p_inactive_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        off_md |=> !pend);

    // R3: software set on an edge source always lands
    p_edge_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_md && sw_set) |=> pend);

    // R5: direct-mode level bit tracks the asserted level
    p_direct_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_md && !msg_mode) |=> (pend == $past(assert_now)));

    // R6: message-mode level bit is never dropped
    p_msg_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level_md && msg_mode && pend) |=> pend);

    // R7: no set while the level source is not asserting
    p_msg_set_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_md && msg_mode && !pend && !assert_now) |=> !pend);

    // R9: a detected edge wins over a clear
    p_edge_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_md && assert_rise) |=> pend);

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_W       = $clog2(NUM_SRC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      msg_mode,
    input  logic [NUM_SRC-1:0]        src_in,
    input  logic [NUM_SRC*MODE_W-1:0] src_mode,
    input  logic                      wr_valid,
    input  logic                      wr_set,
    input  logic [NUM_W-1:0]          wr_num,
    output logic [NUM_SRC-1:0]        pend
);

    logic [NUM_SRC-1:0] lvl_sync;
    logic [NUM_SRC-1:0] sw_set;
    logic [NUM_SRC-1:0] sw_clr;

    irq_pend_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (src_in),
        .dout  (lvl_sync)
    );

    irq_pend_wr_dec #(
        .NUM_SRC (NUM_SRC),
        .NUM_W   (NUM_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_set   (wr_set),
        .wr_num   (wr_num),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        irq_pend_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (src_mode[k*MODE_W +: MODE_W]),
            .msg_mode (msg_mode),
            .lvl      (lvl_sync[k]),
            .sw_set   (sw_set[k]),
            .sw_clr   (sw_clr[k]),
            .pend     (pend[k])
        );
    end

endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;

    localparam int N  = 8;
    localparam int MW = 3;
    localparam int NW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          msg_mode;
    logic [N-1:0]  src_in;
    logic [N*MW-1:0] src_mode;
    logic          wr_valid;
    logic          wr_set;
    logic [NW-1:0] wr_num;
    logic [N-1:0]  pend;
    int            errs   = 0;
    int            checks = 0;

    always #5 clk = ~clk;

    irq_pend_ctrl #(.NUM_SRC(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_mode (msg_mode),
        .src_in   (src_in),
        .src_mode (src_mode),
        .wr_valid (wr_valid),
        .wr_set   (wr_set),
        .wr_num   (wr_num),
        .pend     (pend)
    );

    task automatic chk(input string tag, input logic [N-1:0] exp);
        checks++;
        if (pend !== exp) begin
            errs++;
            $display("FAIL %s: pend=%b expected=%b", tag, pend, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input int src, input logic [MW-1:0] m);
        src_mode[(src-1)*MW +: MW] = m;
    endtask

    task automatic sw_write(input logic s, input int num);
        wr_valid = 1'b1;
        wr_set   = s;
        wr_num   = NW'(num);
        cycles(1);
        wr_valid = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n    = 1'b0;
        msg_mode = 1'b0;
        src_in   = '0;
        src_mode = '0;
        wr_valid = 1'b0;
        wr_set   = 1'b0;
        wr_num   = '0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic t_reset();
        apply_reset();
        chk("R10 reset state", '0);
    endtask

    task automatic t_inactive();
        apply_reset();
        sw_write(1'b1, 1);
        chk("R1 inactive ignores set", '0);
        set_mode(2, 3'd6);
        cycles(1);
        sw_write(1'b1, 2);
        chk("R1 code 6 acts inactive", '0);
        set_mode(3, 3'd1);
        cycles(1);
        sw_write(1'b1, 3);
        chk("R3 edge set before off", 8'b0000_0100);
        set_mode(3, 3'd0);
        cycles(1);
        chk("R1 inactive holds zero", '0);
    endtask

    task automatic t_edge_sw();
        apply_reset();
        set_mode(1, 3'd1);
        set_mode(5, 3'd2);
        cycles(1);
        sw_write(1'b1, 1);
        chk("R3 set src1", 8'b0000_0001);
        sw_write(1'b1, 5);
        chk("R3 set src5", 8'b0001_0001);
        sw_write(1'b0, 1);
        chk("R3 clear src1", 8'b0001_0000);
        sw_write(1'b1, 0);
        chk("R2 number 0 ignored", 8'b0001_0000);
        sw_write(1'b1, 9);
        chk("R2 number 9 ignored", 8'b0001_0000);
        sw_write(1'b0, 13);
        chk("R2 number 13 ignored", 8'b0001_0000);
        sw_write(1'b0, 5);
        chk("R3 clear src5", '0);
    endtask

    task automatic t_edge_hw();
        apply_reset();
        set_mode(1, 3'd1);
        cycles(1);
        src_in[0] = 1'b1;
        cycles(2);
        chk("R4 rise not yet", '0);
        cycles(1);
        chk("R4 rise third edge", 8'b0000_0001);
        sw_write(1'b0, 1);
        chk("R3 clear after rise", '0);
        src_in[0] = 1'b0;
        cycles(4);
        chk("R4 fall ignored in rise mode", '0);
        src_in[1] = 1'b1;
        cycles(4);
        set_mode(2, 3'd2);
        cycles(1);
        chk("R4 no event on mode change", '0);
        src_in[1] = 1'b0;
        cycles(3);
        chk("R4 falling edge sets", 8'b0000_0010);
    endtask

    task automatic t_direct();
        apply_reset();
        set_mode(3, 3'd3);
        set_mode(4, 3'd4);
        cycles(1);
        chk("R5 level-low asserted at low", 8'b0000_1000);
        src_in[2] = 1'b1;
        cycles(2);
        chk("R5 level-high latency", 8'b0000_1000);
        cycles(1);
        chk("R5 level-high follows", 8'b0000_1100);
        sw_write(1'b0, 3);
        chk("R5 direct clear ignored", 8'b0000_1100);
        src_in[2] = 1'b0;
        src_in[3] = 1'b1;
        cycles(3);
        chk("R5 deassert drops", '0);
        sw_write(1'b1, 3);
        chk("R5 direct set ignored", '0);
    endtask

    task automatic t_msg_level();
        apply_reset();
        msg_mode = 1'b1;
        set_mode(4, 3'd3);
        cycles(1);
        sw_write(1'b1, 4);
        chk("R7 high set with input low", '0);
        src_in[3] = 1'b1;
        cycles(3);
        chk("R8 assertion sets", 8'b0000_1000);
        sw_write(1'b0, 4);
        chk("R6 msg clear ignored", 8'b0000_1000);
        src_in[3] = 1'b0;
        cycles(4);
        chk("R8 deassert keeps bit", 8'b0000_1000);
        set_mode(4, 3'd0);
        cycles(1);
        chk("R1 off clears src4", '0);
        src_in[3] = 1'b1;
        cycles(4);
        set_mode(4, 3'd3);
        cycles(1);
        chk("R8 no event on mode change", '0);
        sw_write(1'b1, 4);
        chk("R7 high set with input high", 8'b0000_1000);
        set_mode(5, 3'd4);
        cycles(1);
        chk("R8 low no event at start", 8'b0000_1000);
        sw_write(1'b1, 5);
        chk("R7 low set with input low", 8'b0001_1000);
        src_in[5] = 1'b1;
        cycles(3);
        set_mode(6, 3'd4);
        cycles(1);
        sw_write(1'b1, 6);
        chk("R7 low set with input high", 8'b0001_1000);
    endtask

    task automatic t_collision();
        apply_reset();
        set_mode(1, 3'd1);
        cycles(1);
        src_in[0] = 1'b1;
        cycles(2);
        wr_valid = 1'b1;
        wr_set   = 1'b0;
        wr_num   = NW'(1);
        cycles(1);
        wr_valid = 1'b0;
        chk("R9 edge beats clear", 8'b0000_0001);
        sw_write(1'b0, 1);
        chk("R9 later clear acts", '0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        t_reset();
        t_inactive();
        t_edge_sw();
        t_edge_hw();
        t_direct();
        t_msg_level();
        t_collision();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

endmodule